// File: doc/BRIEF.md
# Four-Way True-LRU Order Tracker

This block holds the exact recency order of the ways in every set of a set-associative cache. For each set it keeps a list of way numbers. The most recently used way sits at the head and the least recently used way sits at the tail. The cache controller presents a set index on every cycle. The block returns, combinationally, the tail of that set's list as the way to evict. It also returns the whole list of that set.

When the controller signals an access, the block rewrites the indexed set's list on the next rising clock edge. On a hit, the named way is promoted to the head. On a miss, the current victim is filled and then promoted to the head. Tags, data and memory traffic are handled elsewhere. Only the ordering lives here, at WAYS·log2(WAYS) bits per set, which is 8 bits for the default four ways.

Top module: `lru_order_tracker`

## Requirements
- R1: While `rst_n` is low at a rising edge, every set is loaded with the order 0,1,2,3 from head to tail, so `victim_way` reads 3 for any set. In `set_order`, entry i (i = 0 is the head) occupies bits [2i+1:2i].
- R2: `victim_way` always equals the tail entry (bits [7:6]) of the set selected by `acc_set`, and it follows a change of `acc_set` within the same cycle, without a clock edge.
- R3: A hit (`acc_valid`=1, `acc_hit`=1) on a way found at position p moves that way to the head. The entries that were at positions 0..p-1 each move back one place, and the entries behind position p stay where they were.
- R4: A hit on the way that is already at the head leaves the list unchanged.
- R5: A miss (`acc_valid`=1, `acc_hit`=0) promotes the current tail way to the head, and every other entry moves back one place. `acc_way` is ignored on a miss.
- R6: When `acc_valid` is low, `acc_hit` and `acc_way` have no effect, and no list changes.
- R7: An access changes only the list of the set given by `acc_set`. All other sets keep their order.
- R8: Every list always holds each way number exactly once.
- R9: Starting from 0,1,2,3, the accesses hit 2, hit 2, miss, hit 1 give 2,0,1,3, then 2,0,1,3, then 3,2,0,1, then 1,3,2,0.
- R10: An update is not visible before the rising edge at which `acc_valid` is sampled high. It is visible on `set_order` and `victim_way` right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all list updates happen on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset to the default order |
| acc_valid | input | 1 | An access to set `acc_set` takes place this cycle |
| acc_set | input | 4 | Set index to read and, with `acc_valid`, to update |
| acc_hit | input | 1 | 1: the access hit way `acc_way`; 0: the access missed |
| acc_way | input | 2 | Way that hit; used only when `acc_hit` is 1 |
| victim_way | output | 2 | Least recently used way of the indexed set |
| set_order | output | 8 | Full list of the indexed set, head in bits [1:0] |

## Verification
Suppose one set's list becomes corrupt, for example with a way number duplicated or lost. That set's `set_order` shows the fault as soon as the set is indexed. `victim_way` may hide it until enough misses walk the damaged entry to the tail. A corrupt list therefore stays invisible to a controller that reads only the victim, which is why the bench reads the whole list after every access. A wrong shift rule, such as moving entries that sit behind the hit position, shows on the very next read of the same set. A wrong set decode shows only when a set that was not touched is read back, so the bench revisits earlier sets after working on others.

// File: rtl/lru_order_pkg.sv
package lru_order_pkg;

   typedef enum logic [1:0] {
      ACC_IDLE = 2'd0,
      ACC_HIT  = 2'd1,
      ACC_MISS = 2'd2
   } acc_kind_e;

   // Index width that stays at least one bit for a single-entry range.
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/lru_list_rotate.sv
// Moves one way number to the head of a recency list. Entries in front of
// its old slot slide back by one; entries behind it are kept.
module lru_list_rotate #(
   parameter  int unsigned WAYS   = 4,
   parameter  int unsigned WAY_W  = 2,
   localparam int unsigned LIST_W = WAYS * WAY_W
) (
   input  logic [LIST_W-1:0] cur_list,
   input  logic [WAY_W-1:0]  promo_way,
   output logic [LIST_W-1:0] next_list
);

   logic [WAY_W-1:0] promo_pos;

   always_comb begin
      promo_pos = '0;
      for (int i = 0; i < WAYS; i++) begin
         if (cur_list[i*WAY_W +: WAY_W] == promo_way) begin
            promo_pos = WAY_W'(i);
         end
      end
   end

   assign next_list[0 +: WAY_W] = promo_way;

   for (genvar p = 1; p < WAYS; p++) begin : g_slot
      assign next_list[p*WAY_W +: WAY_W] = (WAY_W'(p) <= promo_pos)
                                         ? cur_list[(p-1)*WAY_W +: WAY_W]
                                         : cur_list[p*WAY_W +: WAY_W];
   end

endmodule

// File: rtl/lru_victim_pick.sv
// Tail extraction and choice of the way to promote on an access.
module lru_victim_pick #(
   parameter  int unsigned WAYS   = 4,
   parameter  int unsigned WAY_W  = 2,
   localparam int unsigned LIST_W = WAYS * WAY_W
) (
   input  logic [LIST_W-1:0] cur_list,
   input  logic              use_hit_way,
   input  logic [WAY_W-1:0]  hit_way,
   output logic [WAY_W-1:0]  tail_way,
   output logic [WAY_W-1:0]  promo_way
);

   assign tail_way  = cur_list[(WAYS-1)*WAY_W +: WAY_W];
   assign promo_way = use_hit_way ? hit_way : tail_way;

endmodule

// File: rtl/lru_set_store.sv
// Per-set list storage with synchronous reset to the identity order.
module lru_set_store #(
   parameter  int unsigned NUM_SETS = 16,
   parameter  int unsigned WAYS     = 4,
   parameter  int unsigned SET_W    = 4,
   parameter  int unsigned WAY_W    = 2,
   localparam int unsigned LIST_W   = WAYS * WAY_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SET_W-1:0]  rd_set,
   output logic [LIST_W-1:0] rd_list,
   input  logic              wr_en,
   input  logic [SET_W-1:0]  wr_set,
   input  logic [LIST_W-1:0] wr_list
);

   logic [LIST_W-1:0] mem [NUM_SETS];

   function automatic logic [LIST_W-1:0] ident_list();
      logic [LIST_W-1:0] l;
      for (int i = 0; i < WAYS; i++) begin
         l[i*WAY_W +: WAY_W] = WAY_W'(i);
      end
      return l;
   endfunction

   function automatic logic is_perm(input logic [LIST_W-1:0] l);
      logic [WAYS-1:0] seen;
      seen = '0;
      for (int i = 0; i < WAYS; i++) begin
         seen[l[i*WAY_W +: WAY_W]] = 1'b1;
      end
      return &seen;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SETS; s++) begin
            mem[s] <= ident_list();
         end
      end else if (wr_en) begin
         mem[wr_set] <= wr_list;
      end
   end

   assign rd_list = mem[rd_set];

   AST_READ_PERM: assert property (@(posedge clk) disable iff (!rst_n)
      is_perm(rd_list)); // R8
   AST_WRITE_PERM: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> is_perm(wr_list)); // R8

endmodule

// File: rtl/lru_order_tracker.sv
module lru_order_tracker #(
   parameter  int unsigned NUM_SETS = 16,
   parameter  int unsigned WAYS     = 4,
   localparam int unsigned SET_W    = lru_order_pkg::idx_bits(NUM_SETS),
   localparam int unsigned WAY_W    = lru_order_pkg::idx_bits(WAYS),
   localparam int unsigned LIST_W   = WAYS * WAY_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [SET_W-1:0]  acc_set,
   input  logic              acc_hit,
   input  logic [WAY_W-1:0]  acc_way,
   output logic [WAY_W-1:0]  victim_way,
   output logic [LIST_W-1:0] set_order
);

   import lru_order_pkg::*;

   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (NUM_SETS < 1) begin : g_bad_sets
      $error("NUM_SETS must be at least 1");
   end

   acc_kind_e         acc_kind;
   logic [WAY_W-1:0]  promo_way;
   logic [LIST_W-1:0] next_list;

   always_comb begin
      if (!acc_valid)  acc_kind = ACC_IDLE;
      else if (acc_hit) acc_kind = ACC_HIT;
      else              acc_kind = ACC_MISS;
   end

   lru_set_store #(
      .NUM_SETS (NUM_SETS),
      .WAYS     (WAYS),
      .SET_W    (SET_W),
      .WAY_W    (WAY_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_set  (acc_set),
      .rd_list (set_order),
      .wr_en   (acc_kind != ACC_IDLE),
      .wr_set  (acc_set),
      .wr_list (next_list)
   );

   lru_victim_pick #(
      .WAYS  (WAYS),
      .WAY_W (WAY_W)
   ) u_pick (
      .cur_list    (set_order),
      .use_hit_way (acc_kind == ACC_HIT),
      .hit_way     (acc_way),
      .tail_way    (victim_way),
      .promo_way   (promo_way)
   );

   lru_list_rotate #(
      .WAYS  (WAYS),
      .WAY_W (WAY_W)
   ) u_rotate (
      .cur_list  (set_order),
      .promo_way (promo_way),
      .next_list (next_list)
   );

   AST_HIT_TO_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_hit) |=> (acc_set != $past(acc_set)) || (set_order[0 +: WAY_W] == $past(acc_way))); // R3
   AST_HEAD_HIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_hit && acc_way == set_order[0 +: WAY_W]) |=> (acc_set != $past(acc_set)) || $stable(set_order)); // R4
   AST_MISS_FILL_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_hit) |=> (acc_set != $past(acc_set)) || (set_order[0 +: WAY_W] == $past(victim_way))); // R5
   AST_MISS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_hit) |=> (acc_set != $past(acc_set)) || (set_order[WAY_W +: WAY_W] == $past(set_order[0 +: WAY_W]))); // R5
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> (acc_set != $past(acc_set)) || $stable(set_order)); // R6

endmodule

// File: tb/lru_order_tracker_tb.sv
module lru_order_tracker_tb;

   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [3:0] set;
      logic       vld;
      logic       hit;
      logic [1:0] way;
      logic [7:0] exp;
   } vec_t;

   function automatic logic [7:0] ord(input logic [1:0] a, input logic [1:0] b,
                                      input logic [1:0] c, input logic [1:0] d);
      return {d, c, b, a};
   endfunction

   // R9 sequence on set 5, R3/R4/R5/R6 on set 9, full miss cycle on set 0,
   // R7 revisit of set 5, top set 15.
   localparam int NVEC = 17;
   localparam vec_t VECS [NVEC] = '{
      '{4'd5,  1'b1, 1'b1, 2'd2, ord(2'd2, 2'd0, 2'd1, 2'd3)},
      '{4'd5,  1'b1, 1'b1, 2'd2, ord(2'd2, 2'd0, 2'd1, 2'd3)},
      '{4'd5,  1'b1, 1'b0, 2'd0, ord(2'd3, 2'd2, 2'd0, 2'd1)},
      '{4'd5,  1'b1, 1'b1, 2'd1, ord(2'd1, 2'd3, 2'd2, 2'd0)},
      '{4'd9,  1'b0, 1'b1, 2'd3, ord(2'd0, 2'd1, 2'd2, 2'd3)},
      '{4'd9,  1'b1, 1'b1, 2'd3, ord(2'd3, 2'd0, 2'd1, 2'd2)},
      '{4'd9,  1'b1, 1'b1, 2'd1, ord(2'd1, 2'd3, 2'd0, 2'd2)},
      '{4'd9,  1'b1, 1'b0, 2'd1, ord(2'd2, 2'd1, 2'd3, 2'd0)},
      '{4'd9,  1'b1, 1'b1, 2'd0, ord(2'd0, 2'd2, 2'd1, 2'd3)},
      '{4'd9,  1'b1, 1'b1, 2'd0, ord(2'd0, 2'd2, 2'd1, 2'd3)},
      '{4'd9,  1'b1, 1'b0, 2'd2, ord(2'd3, 2'd0, 2'd2, 2'd1)},
      '{4'd0,  1'b1, 1'b0, 2'd0, ord(2'd3, 2'd0, 2'd1, 2'd2)},
      '{4'd0,  1'b1, 1'b0, 2'd0, ord(2'd2, 2'd3, 2'd0, 2'd1)},
      '{4'd0,  1'b1, 1'b0, 2'd0, ord(2'd1, 2'd2, 2'd3, 2'd0)},
      '{4'd0,  1'b1, 1'b0, 2'd0, ord(2'd0, 2'd1, 2'd2, 2'd3)},
      '{4'd5,  1'b0, 1'b0, 2'd0, ord(2'd1, 2'd3, 2'd2, 2'd0)},
      '{4'd15, 1'b1, 1'b1, 2'd2, ord(2'd2, 2'd0, 2'd1, 2'd3)}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_valid = 1'b0;
   logic [3:0] acc_set = '0;
   logic       acc_hit = 1'b0;
   logic [1:0] acc_way = '0;
   logic [1:0] victim_way;
   logic [7:0] set_order;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lru_order_tracker u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_valid  (acc_valid),
      .acc_set    (acc_set),
      .acc_hit    (acc_hit),
      .acc_way    (acc_way),
      .victim_way (victim_way),
      .set_order  (set_order)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic perm_ok(input logic [7:0] l);
      logic [3:0] seen;
      seen = '0;
      for (int i = 0; i < 4; i++) seen[l[2*i +: 2]] = 1'b1;
      return &seen;
   endfunction

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: every set in default order after reset
      for (int s = 0; s < 16; s++) begin
         acc_set = 4'(s);
         #1;
         check("R1 order", set_order, ord(2'd0, 2'd1, 2'd2, 2'd3));
         check("R1 victim", {6'd0, victim_way}, 8'd3);
      end

      // Vector table walk
      for (int v = 0; v < NVEC; v++) begin
         @(negedge clk);
         acc_set   = VECS[v].set;
         acc_valid = VECS[v].vld;
         acc_hit   = VECS[v].hit;
         acc_way   = VECS[v].way;
         @(posedge clk);
         @(negedge clk);
         acc_valid = 1'b0;
         #1;
         check($sformatf("R3/R4/R5/R6/R7/R9 vec %0d order", v), set_order, VECS[v].exp);
         check($sformatf("R2 vec %0d victim", v), {6'd0, victim_way}, {6'd0, VECS[v].exp[7:6]});
         check($sformatf("R8 vec %0d permutation", v), {7'd0, perm_ok(set_order)}, 8'd1);
      end

      // R2: victim follows set index without a clock edge
      acc_set = 4'd5;
      #1;
      check("R2 set5 victim", {6'd0, victim_way}, 8'd0);
      acc_set = 4'd9;
      #1;
      check("R2 set9 victim", {6'd0, victim_way}, 8'd1);

      // R7: a set never accessed is untouched
      acc_set = 4'd3;
      #1;
      check("R7 set3 untouched", set_order, ord(2'd0, 2'd1, 2'd2, 2'd3));

      // R10: no change before the edge, change right after it
      @(negedge clk);
      acc_set   = 4'd15;
      acc_valid = 1'b1;
      acc_hit   = 1'b1;
      acc_way   = 2'd1;
      #1;
      check("R10 before edge", set_order, ord(2'd2, 2'd0, 2'd1, 2'd3));
      @(posedge clk);
      #1;
      check("R10 after edge", set_order, ord(2'd1, 2'd2, 2'd0, 2'd3));
      @(negedge clk);
      acc_valid = 1'b0;

      // R5: acc_way ignored on a miss (set 15 is 1,2,0,3; victim 3)
      @(negedge clk);
      acc_valid = 1'b1;
      acc_hit   = 1'b0;
      acc_way   = 2'd0;
      @(posedge clk);
      @(negedge clk);
      acc_valid = 1'b0;
      #1;
      check("R5 miss ignores way", set_order, ord(2'd3, 2'd1, 2'd2, 2'd0));

      // R1: reset in mid-run restores default order
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      acc_set = 4'd9;
      #1;
      check("R1 reset set9", set_order, ord(2'd0, 2'd1, 2'd2, 2'd3));
      acc_set = 4'd15;
      #1;
      check("R1 reset set15 victim", {6'd0, victim_way}, 8'd3);

      finish_run();
   end

endmodule